// File: doc/BRIEF.md
# Iterative 64-bit Substitution-Permutation Encryption Core

This block encrypts one 64-bit block under an 80-bit key. It is a substitution-permutation cipher with 31 rounds and finishes with an extra key addition. The block runs one full round per clock. A datapath register and a key register are updated side by side, and the round key for each round comes from the key register as it goes.

The surrounding logic presents the plaintext and key on parallel inputs and pulses `start`. The block copies both into its own registers on that edge, so the inputs may change right afterwards. Some cycles later the block pulses `done` for one cycle and updates the `ciphertext` register, which then holds its value until the next result. A three-state controller sequences the work.

The controller has three states:
- `ST_IDLE` is the state after reset. `start` moves it to `ST_RUN` and loads the registers.
- `ST_RUN` executes one round per cycle. When the round count reaches its final value it applies the last key addition and moves to `ST_DONE`.
- `ST_DONE` holds the result. `start` moves it to `ST_RUN` again, otherwise it stays in `ST_DONE`.

Top module: `spn64_enc_core`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and `ciphertext` is all zeros until the first result is produced.
- R2: A `start` high on a clock edge while the core is idle or holding a result copies `plaintext` and `key` into internal registers. Any later change of these inputs does not affect that result.
- R3: Each round XORs the round key into the state and then replaces every nibble (bits 4n+3..4n) through the 4-bit table 0..F -> C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2.
- R4: After substitution, state bit i moves to bit position (16*i) mod 63 for i = 0..62, and bit 63 stays in place.
- R5: The round key is bits 79..16 of the key register. After each round the key register is updated in this order:
  - rotate it left by 61 bit positions;
  - pass bits 79..76 through the substitution table;
  - XOR bits 19..15 with the 5-bit number of the round just executed, counting from 1.
- R6: After round 31 the result is the state XORed with the 32nd round key. An all-zero plaintext gives 5579C1387B228445 under an all-zero key and E72C46C0F5945049 under an all-ones key.
- R7: `done` first goes high in the cycle after the 32nd rising edge that follows the edge sampling `start`, so the result appears in the 33rd cycle counting the start cycle. It is never high earlier.
- R8: `done` is high for exactly one cycle per result.
- R9: `ciphertext` changes only on the edge that raises `done`, and it holds its value between results.
- R10: A `start` sampled while the core is running is ignored. The current operation continues with its original operands and timing.
- R11: A `start` while a result is being held begins a new operation with the same timing as one started from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an encryption with the present operands |
| plaintext | input | 64 | Block to encrypt, sampled with `start` |
| key | input | 80 | Cipher key, sampled with `start` |
| ciphertext | output | 64 | Registered encryption result |
| done | output | 1 | One-cycle pulse when `ciphertext` is updated |

## Verification
The bench builds the core with its default parameters:
- a 64-bit block and an 80-bit key;
- 31 rounds;
- a key rotation of 61;
- the round counter injected at bit 15.

Only these values make the published known-answer vectors and the bench's own reference model comparable with the hardware. Because the round count is the full 31, the counter reaches the top of its 5-bit range. That exercises the final-count detection, the injection of the largest counter value into the key, and the exact 33-cycle timing, together with a start poked into the middle of a run.

// File: rtl/spn64_pkg.sv
package spn64_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } fsm_t;

    // 4-bit substitution used by both the datapath and the key schedule
    function automatic logic [3:0] sbox4(input logic [3:0] x);
        logic [3:0] y;
        unique case (x)
            4'h0: y = 4'hC;
            4'h1: y = 4'h5;
            4'h2: y = 4'h6;
            4'h3: y = 4'hB;
            4'h4: y = 4'h9;
            4'h5: y = 4'h0;
            4'h6: y = 4'hA;
            4'h7: y = 4'hD;
            4'h8: y = 4'h3;
            4'h9: y = 4'hE;
            4'hA: y = 4'hF;
            4'hB: y = 4'h8;
            4'hC: y = 4'h4;
            4'hD: y = 4'h7;
            4'hE: y = 4'h1;
            default: y = 4'h2;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/spn64_ctrl.sv
module spn64_ctrl
    import spn64_pkg::*;
#(
    parameter int ROUNDS = 31,
    parameter int CNT_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output fsm_t             fsm,
    output logic [CNT_W-1:0] cnt,
    output logic             load,
    output logic             step,
    output logic             finish,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS + 1);

    fsm_t fsm_q;
    fsm_t fsm_d;
    logic [CNT_W-1:0] cnt_q;
    logic done_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    // next-state logic
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_IDLE: if (start) fsm_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) fsm_d = ST_DONE;
            ST_DONE: if (start) fsm_d = ST_RUN;
            default: fsm_d = ST_IDLE;
        endcase
    end

    // control strobes
    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        finish = 1'b0;
        unique case (fsm_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                if (cnt_q == LAST) finish = 1'b1;
                else               step   = 1'b1;
            end
            ST_DONE: load = start;
            default: ;
        endcase
    end

    // round counter: 1 during the first round, LAST during the final key addition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(1);
        end else if (step) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish;
    end

    assign fsm  = fsm_q;
    assign cnt  = cnt_q;
    assign done = done_q;

endmodule

// File: rtl/spn64_keysched.sv
module spn64_keysched
    import spn64_pkg::*;
#(
    parameter int KEY_W   = 80,
    parameter int BLK_W   = 64,
    parameter int KEY_ROT = 61,
    parameter int RC_LO   = 15,
    parameter int RC_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [KEY_W-1:0] key_in,
    input  logic [RC_W-1:0]  rnd,
    output logic [BLK_W-1:0] rkey
);

    localparam int BACK = KEY_W - KEY_ROT;

    logic [KEY_W-1:0] kreg;
    logic [KEY_W-1:0] rot;
    logic [KEY_W-1:0] nxt;

    always_comb begin
        rot = {kreg[BACK-1:0], kreg[KEY_W-1:BACK]};
        nxt = rot;
        nxt[KEY_W-1 -: 4]       = sbox4(rot[KEY_W-1 -: 4]);
        nxt[RC_LO +: RC_W]      = rot[RC_LO +: RC_W] ^ rnd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kreg <= '0;
        end else if (load) begin
            kreg <= key_in;
        end else if (step) begin
            kreg <= nxt;
        end
    end

    assign rkey = kreg[KEY_W-1 -: BLK_W];

endmodule

// File: rtl/spn64_round.sv
module spn64_round
    import spn64_pkg::*;
#(
    parameter int BLK_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             finish,
    input  logic [BLK_W-1:0] pt_in,
    input  logic [BLK_W-1:0] rkey,
    output logic [BLK_W-1:0] ct_out
);

    localparam int NIB    = BLK_W / 4;
    localparam int STRIDE = BLK_W / 4;

    logic [BLK_W-1:0] st_q;
    logic [BLK_W-1:0] mixed;
    logic [BLK_W-1:0] subbed;
    logic [BLK_W-1:0] permd;
    logic [BLK_W-1:0] ct_q;

    assign mixed = st_q ^ rkey;

    for (genvar g = 0; g < NIB; g++) begin : g_sub
        assign subbed[g*4 +: 4] = sbox4(mixed[g*4 +: 4]);
    end

    for (genvar b = 0; b < BLK_W; b++) begin : g_perm
        localparam int DST = (b == BLK_W - 1) ? b : (b * STRIDE) % (BLK_W - 1);
        assign permd[DST] = subbed[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (load) begin
            st_q <= pt_in;
        end else if (step) begin
            st_q <= permd;
        end
    end

    // final key addition lands straight in the output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '0;
        end else if (finish) begin
            ct_q <= mixed;
        end
    end

    assign ct_out = ct_q;

endmodule

// File: rtl/spn64_enc_core.sv
module spn64_enc_core
    import spn64_pkg::*;
#(
    parameter int BLK_W   = 64,
    parameter int KEY_W   = 80,
    parameter int ROUNDS  = 31,
    parameter int KEY_ROT = 61,
    parameter int RC_LO   = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BLK_W-1:0] plaintext,
    input  logic [KEY_W-1:0] key,
    output logic [BLK_W-1:0] ciphertext,
    output logic             done
);

    localparam int CNT_W = $clog2(ROUNDS + 2);
    localparam int RC_W  = $clog2(ROUNDS + 1);

    fsm_t             fsm_st;
    logic [CNT_W-1:0] rnd_cnt;
    logic             load;
    logic             step;
    logic             finish;
    logic [BLK_W-1:0] rkey;

    spn64_ctrl #(
        .ROUNDS (ROUNDS),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .fsm    (fsm_st),
        .cnt    (rnd_cnt),
        .load   (load),
        .step   (step),
        .finish (finish),
        .done   (done)
    );

    spn64_keysched #(
        .KEY_W   (KEY_W),
        .BLK_W   (BLK_W),
        .KEY_ROT (KEY_ROT),
        .RC_LO   (RC_LO),
        .RC_W    (RC_W)
    ) u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .key_in (key),
        .rnd    (rnd_cnt[RC_W-1:0]),
        .rkey   (rkey)
    );

    spn64_round #(
        .BLK_W (BLK_W)
    ) u_round (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .finish (finish),
        .pt_in  (plaintext),
        .rkey   (rkey),
        .ct_out (ciphertext)
    );

endmodule

// File: rtl/spn64_enc_core_chk.sv
module spn64_enc_core_chk
    import spn64_pkg::*;
#(
    parameter int BLK_W  = 64,
    parameter int ROUNDS = 31,
    parameter int CNT_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [BLK_W-1:0] ct,
    input fsm_t             fsm,
    input logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS + 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_CT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ct)); // R9

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(fsm) == ST_RUN && $past(cnt) == LAST)); // R7

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == ST_RUN) |-> (cnt >= ONE && cnt <= LAST)); // R7

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm != ST_RUN && start) |=> (fsm == ST_RUN && cnt == ONE)); // R2

    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == ST_RUN && cnt != LAST && start) |=> (fsm == ST_RUN && cnt == $past(cnt) + ONE)); // R10

endmodule

bind spn64_enc_core spn64_enc_core_chk #(
    .BLK_W  (BLK_W),
    .ROUNDS (ROUNDS),
    .CNT_W  (CNT_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .done  (done),
    .ct    (ciphertext),
    .fsm   (fsm_st),
    .cnt   (rnd_cnt)
);

// File: tb/spn64_enc_core_test.sv
module spn64_enc_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] pt_i = '0;
    logic [79:0] key_i = '0;
    logic [63:0] ct_o;
    logic        done_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    spn64_enc_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .plaintext  (pt_i),
        .key        (key_i),
        .ciphertext (ct_o),
        .done       (done_o)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [3:0] tsub(input logic [3:0] x);
        logic [63:0] tbl = 64'h21748FE3DA09B65C;
        return tbl[x*4 +: 4];
    endfunction

    function automatic logic [63:0] ref_enc(input logic [63:0] p, input logic [79:0] k);
        logic [63:0] s = p;
        logic [63:0] t;
        logic [79:0] kk = k;
        for (int r = 1; r <= 31; r++) begin
            s = s ^ kk[79:16];
            for (int n = 0; n < 16; n++) s[n*4 +: 4] = tsub(s[n*4 +: 4]);
            for (int b = 0; b < 64; b++) t[(b == 63) ? 63 : (b * 16) % 63] = s[b];
            s = t;
            kk = {kk[18:0], kk[79:19]};
            kk[79:76] = tsub(kk[79:76]);
            kk[19:15] = kk[19:15] ^ 5'(r);
        end
        return s ^ kk[79:16];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one encryption; optionally poke start while running (R10)
    task automatic run_op(input logic [63:0] p, input logic [79:0] k, input bit poke);
        logic [63:0] exp = ref_enc(p, k);
        int early = 0;
        @(negedge clk);
        pt_i = p; key_i = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0; pt_i = ~p; key_i = ~k;   // R2: operands already captured
        for (int e = 1; e <= 32; e++) begin
            @(negedge clk);
            if (poke && e == 5) begin
                start = 1'b1; pt_i = {$urandom, $urandom};
            end
            if (poke && e == 6) start = 1'b0;
            if (e < 32 && done_o) early++;
        end
        check(early == 0, "R7 no early done", 64'(early), 64'd0);
        check(done_o == 1'b1, "R7 done at 33rd cycle", 64'(done_o), 64'd1);
        check(ct_o == exp, poke ? "R10 R3 R4 R5 R6 result" : "R2 R3 R4 R5 R6 result", ct_o, exp);
        @(negedge clk);
        check(done_o == 1'b0, "R8 done single cycle", 64'(done_o), 64'd0);
        check(ct_o == exp, "R9 ciphertext held", ct_o, exp);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        #35;
        check(done_o == 1'b0, "R1 done in reset", 64'(done_o), 64'd0);
        check(ct_o == '0, "R1 ciphertext in reset", ct_o, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R1 done idle", 64'(done_o), 64'd0);
        check(ct_o == '0, "R1 ciphertext idle", ct_o, 64'd0);

        // known answers (R6); first run starts from idle, later ones from held result (R11)
        run_op(64'h0, 80'h0, 1'b0);
        check(ct_o == 64'h5579C1387B228445, "R6 zero key vector", ct_o, 64'h5579C1387B228445);
        run_op(64'h0, {80{1'b1}}, 1'b0);
        check(ct_o == 64'hE72C46C0F5945049, "R6 R11 ones key vector", ct_o, 64'hE72C46C0F5945049);
        run_op({64{1'b1}}, 80'h0, 1'b0);
        run_op({64{1'b1}}, {80{1'b1}}, 1'b0);

        // start while running must be ignored (R10)
        run_op(64'h0123_4567_89AB_CDEF, 80'h0, 1'b1);

        // hold in DONE without start (R9)
        repeat (5) @(negedge clk);
        check(ct_o == ref_enc(64'h0123_4567_89AB_CDEF, 80'h0), "R9 hold while idle in done",
              ct_o, ref_enc(64'h0123_4567_89AB_CDEF, 80'h0));
        check(done_o == 1'b0, "R8 no spurious done", 64'(done_o), 64'd0);

        // random operands (R3 R4 R5 R11)
        for (int i = 0; i < 12; i++) begin
            run_op({$urandom, $urandom}, {16'($urandom), $urandom, $urandom}, (i % 4) == 3);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule